// File: doc/BRIEF.md
# Ring Access Violation Checker

This block judges a single memory reference against the ring-bracket protection rules of a segmented, ring-protected address space. It is given the reference kind (plain operand read, control transfer, or protected procedure call), the ring brackets and permission bits of the target segment's descriptor, the segment length bound, the ring and segment of the procedure that is running, the ring, segment and word address of the target, an absolute-mode flag and a ring-alarm threshold. From these it forms a 16-bit violation mask and the effective ring the reference proceeds in.

Each reference kind has its own rule set. Every rule that fails sets its own mask bit, and the bits of all failing rules are collected into one mask. A nonzero mask means the caller must raise an access fault. For a protected call the effective ring is also pulled down to the top of the write bracket. The descriptor lookup and the fault sequence itself belong to the surrounding logic.

A reference is presented together with a one-cycle valid strobe. The mask and ring are registered and appear on the clock edge after the strobe, together with a valid output.

Top module: `ring_guard`

## Requirements
- R1: `refKind` encodes 0 = plain read, 1 = transfer, 2 = protected call, 3 = plain read. For every kind, mask bit 0 is set exactly when the brackets are not ordered as `r1 <= r2 <= r3`.
- R2: For a plain read, mask bit 3 is set exactly when the incoming target ring is greater than `r2`.
- R3: For a plain read with `permRead` low, the effective ring is `curRing` and mask bit 4 is set exactly when `curSeg != tgtSeg`. With `permRead` high, the effective ring is `tgtRing` and bit 4 stays clear.
- R4: For a protected call, bit 2 is set when `permExec` is low. Bit 7 is set when `compAddr >= entryBound`, except that this test is skipped when `gateBit` is high, or when `curSeg == tgtSeg` and `absMode` is low.
- R5: For a protected call, bit 8 is set when `tgtRing > r3`, bit 9 when `tgtRing < r1`, and bit 10 when `tgtRing > curRing` and `curRing < r2`. The effective ring is `tgtRing` clamped down to `r2`.
- R6: For a transfer, bit 1 is set when `tgtRing` lies outside `[r1, r2]`, bit 2 when `permExec` is low, and bit 12 when `curRing != tgtRing`. The effective ring is `tgtRing`.
- R7: For a transfer with `alarmRing` nonzero, bit 13 is set unless `curRing < alarmRing`. With `alarmRing` zero, bit 13 stays clear.
- R8: For every kind, bit 15 is set exactly when `compAddr[17:4]` is greater than `segBound`.
- R9: A rule belonging to one kind never sets a bit for another kind. Mask bits 5, 6, 11 and 14 are always zero.
- R10: While `rstN` is low, `outValid`, `outMask` and `outRing` are zero. `outValid` is high for exactly the cycle after a cycle with `inValid` high, and `outMask` and `outRing` then hold that reference's result. When `inValid` is low, they keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Strobe: the reference on the inputs is to be judged |
| refKind | input | 2 | Reference kind (0 read, 1 transfer, 2 call, 3 read) |
| r1 | input | 3 | Descriptor write-bracket low ring |
| r2 | input | 3 | Descriptor read/write-bracket top ring |
| r3 | input | 3 | Descriptor call-bracket top ring |
| permRead | input | 1 | Descriptor read permission |
| permExec | input | 1 | Descriptor execute permission |
| gateBit | input | 1 | Descriptor: segment callable at any word |
| entryBound | input | 14 | Highest legal call entry (exclusive) |
| segBound | input | 14 | Segment length bound in 16-word blocks |
| curRing | input | 3 | Ring of the running procedure |
| curSeg | input | 15 | Segment of the running procedure |
| tgtRing | input | 3 | Ring of the reference |
| tgtSeg | input | 15 | Segment of the reference |
| compAddr | input | 18 | Computed word address within the segment |
| absMode | input | 1 | Processor is in absolute mode |
| alarmRing | input | 3 | Ring-alarm threshold, 0 = off |
| outValid | output | 1 | Result valid |
| outMask | output | 16 | Violation mask |
| outRing | output | 3 | Effective ring |

## Verification
The sweep covers every bracket triple for every kind with the other fields drawn so that segment equality, a zero alarm value and addresses just above, at and below both bounds all come up often. A design that tested `>` where `>=` belongs would miss bit 7 at the exact entry bound, or flag bit 15 there. A design that checked bit 3 after replacing the target ring, or bit 10 after clamping, would give wrong bits on inward reads and calls. One that ignored the gate or absolute-mode skip, or ran the alarm test with a zero threshold, would set bits 7 or 13 where they must stay clear. Directed cycles check that the result does not move between strobes.

// File: rtl/ring_guard_pkg.sv
package ring_guard_pkg;

  localparam int MASK_W = 16;

  typedef enum logic [1:0] {
    REF_READ = 2'd0,
    REF_XFER = 2'd1,
    REF_CALL = 2'd2,
    REF_RSVD = 2'd3
  } refKind_t;

  // violation mask bit positions
  localparam int BIT_ORDER    = 0;
  localparam int BIT_XRANGE   = 1;
  localparam int BIT_NOEXEC   = 2;
  localparam int BIT_RDRING   = 3;
  localparam int BIT_RDSEG    = 4;
  localparam int BIT_ENTRY    = 7;
  localparam int BIT_ABOVER3  = 8;
  localparam int BIT_BELOWR1  = 9;
  localparam int BIT_INWARD   = 10;
  localparam int BIT_XRING    = 12;
  localparam int BIT_ALARM    = 13;
  localparam int BIT_BOUND    = 15;

  typedef struct packed {
    logic load;
    logic isRead;
    logic isXfer;
    logic isCall;
  } ctrlStrobes_t;

endpackage

// File: rtl/ring_guard_ctrl.sv
module ring_guard_ctrl
  import ring_guard_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic [1:0]   refKind,
  output ctrlStrobes_t strobes,
  output logic         outValid
);

  refKind_t kind;

  always_comb begin
    kind           = refKind_t'(refKind);
    strobes.load   = inValid;
    strobes.isXfer = (kind == REF_XFER);
    strobes.isCall = (kind == REF_CALL);
    // the spare code falls back to the plain read rules
    strobes.isRead = (kind == REF_READ) || (kind == REF_RSVD);
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

endmodule

// File: rtl/ring_guard_dp.sv
module ring_guard_dp
  import ring_guard_pkg::*;
#(
  parameter int RING_W  = 3,
  parameter int SEG_W   = 15,
  parameter int ADDR_W  = 18,
  parameter int BOUND_W = 14,
  parameter int ENTRY_W = 14
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobes_t        strobes,
  input  logic [RING_W-1:0]   r1,
  input  logic [RING_W-1:0]   r2,
  input  logic [RING_W-1:0]   r3,
  input  logic                permRead,
  input  logic                permExec,
  input  logic                gateBit,
  input  logic [ENTRY_W-1:0]  entryBound,
  input  logic [BOUND_W-1:0]  segBound,
  input  logic [RING_W-1:0]   curRing,
  input  logic [SEG_W-1:0]    curSeg,
  input  logic [RING_W-1:0]   tgtRing,
  input  logic [SEG_W-1:0]    tgtSeg,
  input  logic [ADDR_W-1:0]   compAddr,
  input  logic                absMode,
  input  logic [RING_W-1:0]   alarmRing,
  output logic [MASK_W-1:0]   outMask,
  output logic [RING_W-1:0]   outRing
);

  localparam int BLOCK_SHIFT = ADDR_W - BOUND_W;

  logic [BOUND_W-1:0] addrBlock;
  logic [ADDR_W-1:0]  entryWide;
  logic               sameSeg;
  logic               skipEntry;
  logic [MASK_W-1:0]  nextMask;
  logic [RING_W-1:0]  nextRing;

  assign addrBlock = compAddr[ADDR_W-1:BLOCK_SHIFT];
  assign entryWide = ADDR_W'(entryBound);
  assign sameSeg   = (curSeg == tgtSeg);
  assign skipEntry = gateBit || (sameSeg && !absMode);

  always_comb begin
    nextMask = '0;
    nextRing = tgtRing;

    if (!((r1 <= r2) && (r2 <= r3))) nextMask[BIT_ORDER] = 1'b1;
    if (addrBlock > segBound)        nextMask[BIT_BOUND] = 1'b1;

    if (strobes.isCall) begin
      if (!permExec)                              nextMask[BIT_NOEXEC]  = 1'b1;
      if (!skipEntry && (compAddr >= entryWide))  nextMask[BIT_ENTRY]   = 1'b1;
      if (tgtRing > r3)                           nextMask[BIT_ABOVER3] = 1'b1;
      if (tgtRing < r1)                           nextMask[BIT_BELOWR1] = 1'b1;
      if ((tgtRing > curRing) && (curRing < r2))  nextMask[BIT_INWARD]  = 1'b1;
      if (tgtRing > r2)                           nextRing = r2;
    end else if (strobes.isXfer) begin
      if ((tgtRing < r1) || (tgtRing > r2))       nextMask[BIT_XRANGE]  = 1'b1;
      if (!permExec)                              nextMask[BIT_NOEXEC]  = 1'b1;
      if (curRing != tgtRing)                     nextMask[BIT_XRING]   = 1'b1;
      if ((alarmRing != '0) && !(curRing < alarmRing))
                                                  nextMask[BIT_ALARM]   = 1'b1;
    end else if (strobes.isRead) begin
      if (tgtRing > r2)                           nextMask[BIT_RDRING]  = 1'b1;
      if (!permRead) begin
        nextRing = curRing;
        if (!sameSeg)                             nextMask[BIT_RDSEG]   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outMask <= '0;
      outRing <= '0;
    end else if (strobes.load) begin
      outMask <= nextMask;
      outRing <= nextRing;
    end
  end

endmodule

// File: rtl/ring_guard.sv
module ring_guard
  import ring_guard_pkg::*;
#(
  parameter int RING_W  = 3,
  parameter int SEG_W   = 15,
  parameter int ADDR_W  = 18,
  parameter int BOUND_W = 14,
  parameter int ENTRY_W = 14
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [1:0]         refKind,
  input  logic [RING_W-1:0]  r1,
  input  logic [RING_W-1:0]  r2,
  input  logic [RING_W-1:0]  r3,
  input  logic               permRead,
  input  logic               permExec,
  input  logic               gateBit,
  input  logic [ENTRY_W-1:0] entryBound,
  input  logic [BOUND_W-1:0] segBound,
  input  logic [RING_W-1:0]  curRing,
  input  logic [SEG_W-1:0]   curSeg,
  input  logic [RING_W-1:0]  tgtRing,
  input  logic [SEG_W-1:0]   tgtSeg,
  input  logic [ADDR_W-1:0]  compAddr,
  input  logic               absMode,
  input  logic [RING_W-1:0]  alarmRing,
  output logic               outValid,
  output logic [15:0]        outMask,
  output logic [RING_W-1:0]  outRing
);

  ctrlStrobes_t strobes;

  ring_guard_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .refKind  (refKind),
    .strobes  (strobes),
    .outValid (outValid)
  );

  ring_guard_dp #(
    .RING_W  (RING_W),
    .SEG_W   (SEG_W),
    .ADDR_W  (ADDR_W),
    .BOUND_W (BOUND_W),
    .ENTRY_W (ENTRY_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .r1         (r1),
    .r2         (r2),
    .r3         (r3),
    .permRead   (permRead),
    .permExec   (permExec),
    .gateBit    (gateBit),
    .entryBound (entryBound),
    .segBound   (segBound),
    .curRing    (curRing),
    .curSeg     (curSeg),
    .tgtRing    (tgtRing),
    .tgtSeg     (tgtSeg),
    .compAddr   (compAddr),
    .absMode    (absMode),
    .alarmRing  (alarmRing),
    .outMask    (outMask),
    .outRing    (outRing)
  );

endmodule

// File: rtl/ring_guard_checks.sv
module ring_guard_checks #(
  parameter int RING_W  = 3,
  parameter int SEG_W   = 15,
  parameter int ADDR_W  = 18,
  parameter int BOUND_W = 14,
  parameter int ENTRY_W = 14
) (
  input logic               clk,
  input logic               rstN,
  input logic               inValid,
  input logic [1:0]         refKind,
  input logic [RING_W-1:0]  r1,
  input logic [RING_W-1:0]  r2,
  input logic [RING_W-1:0]  r3,
  input logic               permRead,
  input logic               permExec,
  input logic               gateBit,
  input logic [ENTRY_W-1:0] entryBound,
  input logic [BOUND_W-1:0] segBound,
  input logic [RING_W-1:0]  curRing,
  input logic [SEG_W-1:0]   curSeg,
  input logic [RING_W-1:0]  tgtRing,
  input logic [SEG_W-1:0]   tgtSeg,
  input logic [ADDR_W-1:0]  compAddr,
  input logic               absMode,
  input logic [RING_W-1:0]  alarmRing,
  input logic               outValid,
  input logic [15:0]        outMask,
  input logic [RING_W-1:0]  outRing
);

  assert_bracket_order_R1: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (r1 > r2)) |=> outMask[0]);

  assert_call_clamp_R5: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && refKind == 2'd2) |=> (outRing <= $past(r2)) && (outRing <= $past(tgtRing)));

  assert_read_no_foreign_bits_R9: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && refKind == 2'd0) |=> (outMask[13:5] == '0) && (outMask[2:1] == '0));

  assert_spare_bits_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outMask[6:5] == '0) && !outMask[11] && !outMask[14]);

  assert_seg_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (compAddr[ADDR_W-1:ADDR_W-BOUND_W] > segBound)) |=> outMask[15]);

  assert_valid_follows_R10: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  assert_valid_drops_R10: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(outMask) && $stable(outRing)));

endmodule

bind ring_guard ring_guard_checks #(
  .RING_W  (RING_W),
  .SEG_W   (SEG_W),
  .ADDR_W  (ADDR_W),
  .BOUND_W (BOUND_W),
  .ENTRY_W (ENTRY_W)
) u_checks (.*);

// File: tb/test_ring_guard.sv
module test_ring_guard;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [1:0]  refKind = '0;
  logic [2:0]  r1 = '0, r2 = '0, r3 = '0;
  logic        permRead = 1'b0, permExec = 1'b0, gateBit = 1'b0;
  logic [13:0] entryBound = '0, segBound = '0;
  logic [2:0]  curRing = '0, tgtRing = '0, alarmRing = '0;
  logic [14:0] curSeg = '0, tgtSeg = '0;
  logic [17:0] compAddr = '0;
  logic        absMode = 1'b0;
  logic        outValid;
  logic [15:0] outMask;
  logic [2:0]  outRing;

  int checks = 0;
  int fails = 0;
  logic [31:0] st = 32'h1234_5678;

  always #10 clk = ~clk;

  ring_guard i_ring_guard (
    .clk(clk), .rstN(rstN), .inValid(inValid), .refKind(refKind),
    .r1(r1), .r2(r2), .r3(r3), .permRead(permRead), .permExec(permExec),
    .gateBit(gateBit), .entryBound(entryBound), .segBound(segBound),
    .curRing(curRing), .curSeg(curSeg), .tgtRing(tgtRing), .tgtSeg(tgtSeg),
    .compAddr(compAddr), .absMode(absMode), .alarmRing(alarmRing),
    .outValid(outValid), .outMask(outMask), .outRing(outRing)
  );

  // expected result: {ring, mask}
  function automatic logic [18:0] model();
    logic [15:0] m;
    logic [2:0]  rg;
    m  = '0;
    rg = tgtRing;
    if (!(r1 <= r2 && r2 <= r3)) m[0] = 1'b1;            // R1
    if (compAddr[17:4] > segBound) m[15] = 1'b1;          // R8
    if (refKind == 2'd2) begin
      if (!permExec) m[2] = 1'b1;                         // R4
      if (!(gateBit || (curSeg == tgtSeg && !absMode)) &&
          compAddr >= {4'd0, entryBound}) m[7] = 1'b1;    // R4
      if (tgtRing > r3) m[8] = 1'b1;                      // R5
      if (tgtRing < r1) m[9] = 1'b1;                      // R5
      if (tgtRing > curRing && curRing < r2) m[10] = 1'b1;
      if (tgtRing > r2) rg = r2;
    end else if (refKind == 2'd1) begin
      if (tgtRing < r1 || tgtRing > r2) m[1] = 1'b1;      // R6
      if (!permExec) m[2] = 1'b1;
      if (curRing != tgtRing) m[12] = 1'b1;
      if (alarmRing != 0 && !(curRing < alarmRing)) m[13] = 1'b1; // R7
    end else begin
      if (tgtRing > r2) m[3] = 1'b1;                      // R2
      if (!permRead) begin                                // R3
        rg = curRing;
        if (curSeg != tgtSeg) m[4] = 1'b1;
      end
    end
    return {rg, m};
  endfunction

  function automatic string tagOf(input int b);
    case (b)
      0:  return "R1";
      3:  return "R2";
      4:  return "R3";
      7:  return "R4";
      8, 9, 10: return "R5";
      1, 12: return "R6";
      2:  return (refKind == 2'd2) ? "R4" : "R6";
      13: return "R7";
      15: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic checkVal(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic nextRand();
    st = st * 32'd1664525 + 32'd1013904223;
  endtask

  task automatic fillFields();
    logic [13:0] blk;
    nextRand(); permRead = st[31]; permExec = st[30]; gateBit = st[29];
    absMode = st[28]; curRing = st[27:25]; tgtRing = st[24:22];
    curSeg = {13'd0, st[21:20]}; tgtSeg = {13'd0, st[19:18]};
    alarmRing = st[17] ? 3'd0 : st[16:14];
    nextRand(); compAddr = st[31:14];
    blk = compAddr[17:4];
    segBound   = blk + 14'(st[2:0]) - 14'd3;
    entryBound = compAddr[13:0] + 14'(st[5:3]) - 14'd3;
  endtask

  task automatic applyAndCheck();
    logic [18:0] exp;
    exp = model();
    inValid = 1'b1;
    @(negedge clk);
    checks++;
    if (outValid !== 1'b1 || outMask !== exp[15:0] || outRing !== exp[18:16]) begin
      fails++;
      if (outValid !== 1'b1)
        $display("FAIL R10: outValid actual %b expected 1", outValid);
      for (int b = 0; b < 16; b++)
        if (outMask[b] !== exp[b])
          $display("FAIL %s: kind %0d mask bit %0d actual %b expected %b (mask %h vs %h)",
                   tagOf(b), refKind, b, outMask[b], exp[b], outMask, exp[15:0]);
      if (outRing !== exp[18:16])
        $display("FAIL %s: kind %0d ring actual %0d expected %0d",
                 (refKind == 2'd2) ? "R5" : "R3", refKind, outRing, exp[18:16]);
    end
  endtask

  initial begin
    int wd = 0;
    while (wd < 100000) begin
      @(posedge clk);
      wd++;
    end
    fails++;
    $display("FAIL R10: watchdog expired actual hung expected done");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] heldMask;
    logic [2:0]  heldRing;
    repeat (3) @(negedge clk);
    // reset state, R10
    checkVal("R10", {31'd0, outValid}, 32'd0);
    checkVal("R10", {16'd0, outMask}, 32'd0);
    checkVal("R10", {29'd0, outRing}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    checkVal("R10", {31'd0, outValid}, 32'd0);

    // directed R7: zero alarm never flags; alarm at current ring flags
    refKind = 2'd1; r1 = 3'd1; r2 = 3'd4; r3 = 3'd5; permExec = 1'b1;
    curRing = 3'd3; tgtRing = 3'd3; compAddr = '0; segBound = 14'd5;
    alarmRing = 3'd0;
    applyAndCheck();
    alarmRing = 3'd3;
    applyAndCheck();
    checkVal("R7", {31'd0, outMask[13]}, 32'd1);

    // directed R4: gate skips entry test; exact entry bound flags
    refKind = 2'd2; gateBit = 1'b0; absMode = 1'b1; curSeg = 15'd2; tgtSeg = 15'd2;
    compAddr = 18'd40; entryBound = 14'd40; tgtRing = 3'd3; curRing = 3'd3;
    applyAndCheck();
    checkVal("R4", {31'd0, outMask[7]}, 32'd1);
    gateBit = 1'b1;
    applyAndCheck();
    checkVal("R4", {31'd0, outMask[7]}, 32'd0);

    // hold, R10
    inValid = 1'b0;
    heldMask = outMask; heldRing = outRing;
    refKind = 2'd0; r1 = 3'd7; tgtRing = 3'd7; compAddr = '1;
    @(negedge clk);
    checkVal("R10", {31'd0, outValid}, 32'd0);
    checkVal("R10", {16'd0, outMask}, {16'd0, heldMask});
    checkVal("R10", {29'd0, outRing}, {29'd0, heldRing});

    // sweep: every kind x every bracket triple, R1..R9
    for (int k = 0; k < 4; k++)
      for (int t = 0; t < 512; t++) begin
        refKind = 2'(k);
        r1 = 3'(t >> 6); r2 = 3'(t >> 3); r3 = 3'(t);
        fillFields();
        applyAndCheck();
      end
    inValid = 1'b0;
    @(negedge clk);
    checkVal("R10", {31'd0, outValid}, 32'd0);

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule